// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Byte Lanes and Refresh

This block sits between a synchronous request port and a 16-bit asynchronous DRAM that has one column strobe per byte lane and an active-low row strobe. A request carries a word address (upper half row, lower half column), write data, a per-byte lane mask and a read/write flag. The controller turns each request into a strobe sequence. It puts the row on the shared address pins while the row strobe falls and the column while the column strobes are low. Writes drive the data pins, and reads sample the data pins a fixed number of clocks into the column strobe.

After an access the row is left open. A later request to the same row goes straight to a column cycle, which is page mode. A request to a different row first closes the page and waits out the precharge time. A free-running interval timer raises a refresh request. A pending refresh blocks new requests, closes any open page and then runs a refresh in which the column strobes fall before the row strobe. The precharge time, row-to-column delay, column pulse width, read sample point and refresh interval are all parameters counted in system clocks.

Top module: `page_dram_ctrl`

## Requirements
- R1: While reset is held, the row strobe, both column strobes, write enable and output enable are high, `reqReady` is low and `rdValid` is low. After reset the controller spends T_RP cycles with the row strobe high before it can accept a request.
- R2: `memAddr` carries the row (`reqAddr[19:10]`) while the row strobe is low with no column strobe active. It carries the column (`reqAddr[9:0]`) in the setup cycle before the column strobes fall and for as long as they stay low.
- R3: For a newly opened row, the column strobes fall exactly T_RCD+1 cycles after the row strobe falls.
- R4: `memCasN[0]` (bits 7:0) is driven low only when mask bit 0 is set, and `memCasN[1]` (bits 15:8) only when mask bit 1 is set. A mask of 00 is treated as 11.
- R5: For a write, `memWeN` goes low and `memDoutEn` goes high one cycle before the column strobes fall. Both hold until the strobes rise, with `memDout` equal to the request data. For a read, `memWeN` stays high and `memOeN` is low exactly while the column strobes are low. The two enables are never low together.
- R6: An access holds its column strobes low for exactly T_CAS cycles.
- R7: For a read, `rdValid` is high for one cycle, beginning at the clock edge T_LAT cycles after the column strobes fell. `rdData` then holds the data-pin lanes sampled at that edge, with unselected lanes reading zero.
- R8: With no refresh pending, a request to the open row is accepted while the row strobe stays low. Requests are accepted only in the idle or open-page states and never while a column strobe is low.
- R9: A request to a different row raises the row strobe (column strobes high), holds it high T_RP cycles, then opens the new row.
- R10: A refresh request is raised every REF_INTERVAL cycles, counted from reset.
- R11: A refresh drops both column strobes while the row strobe is high, drops the row strobe one cycle later with write enable high, holds both low for T_RCD+T_CAS cycles, then raises them together and precharges for T_RP cycles.
- R12: While a refresh is pending, `reqReady` is low. An open page is closed and precharged for T_RP cycles before the refresh begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted at this edge when reqValid is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 20 | Word address, row in [19:10], column in [9:0] |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Byte lane enables, bit 0 = low byte |
| rdValid | output | 1 | Read data valid pulse |
| rdData | output | 16 | Read data |
| memAddr | output | 10 | Multiplexed row/column address pins |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 2 | Column strobes per byte lane, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memDout | output | 16 | Data driven toward the DRAM |
| memDoutEn | output | 1 | Enable for memDout on the shared data pins |
| memDin | input | 16 | Data returned from the DRAM pins |

## Verification
The bound checker watches the strobe ordering on every cycle. It checks that a column strobe falling with the row strobe high is followed by the row strobe falling, that write enable only falls with both column strobes high, and that the two enables are never low together. It also checks that read data only follows a cycle with output enable low, that a page-hit acceptance keeps the row open, and that the row strobe never rises under an active column strobe. The exact delays (T_RCD+1 to the column strobe, T_CAS pulse widths, T_RP precharge before refresh), the lane and address contents and the refresh rate are shown only by the bench's scenarios. These include byte masks, page hits and misses, and refreshes that land on an open page, all compared against the behavioural model.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [2:0] {
    S_PRE,    // row strobe high, precharging
    S_IDLE,   // precharged, no row open
    S_ACT,    // row strobe low, row-to-column delay
    S_COLSU,  // column address and write enable set up, strobes high
    S_CASLO,  // column strobes low
    S_OPEN,   // row held open, waiting for next access
    S_REFC,   // refresh: column strobes low, row strobe high
    S_REFR    // refresh: both strobes low
  } pdcState_t;

  typedef struct packed {
    logic loadReq;    // latch the accepted request
    logic selCol;     // column half on the address pins
    logic driveData;  // enable write data onto the pins
    logic capture;    // sample read data this edge
  } pdcStrobe_t;

endpackage

// File: rtl/pdc_datapath.sv
module pdc_datapath
  import pdc_pkg::*;
#(
  parameter int ADDR_BITS = 10,
  parameter int DATA_W    = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pdcStrobe_t             ctl,
  input  logic [2*ADDR_BITS-1:0] reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  input  logic [DATA_W/8-1:0]    reqMask,
  input  logic                   reqWrite,
  input  logic [DATA_W-1:0]      memDin,
  output logic                   rowHit,
  output logic [DATA_W/8-1:0]    curMask,
  output logic                   curWrite,
  output logic [ADDR_BITS-1:0]   memAddr,
  output logic [DATA_W-1:0]      memDout,
  output logic                   memDoutEn,
  output logic                   rdValid,
  output logic [DATA_W-1:0]      rdData
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_BITS-1:0] latRow, latCol;
  logic [DATA_W-1:0]    latData, capWord;
  logic [LANES-1:0]     normMask;

  // an empty mask selects every lane
  assign normMask = (reqMask == '0) ? '1 : reqMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latRow   <= '0;
      latCol   <= '0;
      latData  <= '0;
      curMask  <= '1;
      curWrite <= 1'b0;
    end else if (ctl.loadReq) begin
      latRow   <= reqAddr[2*ADDR_BITS-1:ADDR_BITS];
      latCol   <= reqAddr[ADDR_BITS-1:0];
      latData  <= reqWdata;
      curMask  <= normMask;
      curWrite <= reqWrite;
    end
  end

  assign rowHit    = (reqAddr[2*ADDR_BITS-1:ADDR_BITS] == latRow);
  assign memAddr   = ctl.selCol ? latCol : latRow;
  assign memDout   = latData;
  assign memDoutEn = ctl.driveData;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign capWord[g*8 +: 8] = curMask[g] ? memDin[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= ctl.capture;
      if (ctl.capture) rdData <= capWord;
    end
  end

endmodule

// File: rtl/pdc_control.sv
module pdc_control
  import pdc_pkg::*;
#(
  parameter int T_RP         = 3,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 3,
  parameter int T_LAT        = 2,
  parameter int REF_INTERVAL = 12500,
  parameter int LANES        = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             rowHit,
  input  logic [LANES-1:0] curMask,
  input  logic             curWrite,
  output logic             reqReady,
  output pdcStrobe_t       ctl,
  output logic             memRasN,
  output logic [LANES-1:0] memCasN,
  output logic             memWeN,
  output logic             memOeN
);

  localparam int REF_LEN = T_RCD + T_CAS;
  localparam int LONGEST = (REF_LEN > T_RP) ? REF_LEN : T_RP;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam int REF_W   = $clog2(REF_INTERVAL);

  localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RCD_LOAD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] CAS_LOAD = CNT_W'(T_CAS - 1);
  localparam logic [CNT_W-1:0] REF_LOAD = CNT_W'(REF_LEN - 1);
  localparam logic [CNT_W-1:0] CAP_AT   = CNT_W'(T_CAS - T_LAT);
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(REF_INTERVAL - 1);

  pdcState_t        st, stNext;
  logic [CNT_W-1:0] waitCnt, waitNext;
  logic [REF_W-1:0] refTimer;
  logic             refPend, accept, cntDone;

  assign cntDone  = (waitCnt == '0);
  assign reqReady = !refPend && (st == S_IDLE || (st == S_OPEN && rowHit));
  assign accept   = reqValid && reqReady;

  always_comb begin
    stNext   = st;
    waitNext = cntDone ? '0 : waitCnt - 1'b1;
    case (st)
      S_PRE:   if (cntDone) stNext = S_IDLE;
      S_IDLE: begin
        if (refPend) begin
          stNext = S_REFC;
        end else if (accept) begin
          stNext   = S_ACT;
          waitNext = RCD_LOAD;
        end
      end
      S_ACT:   if (cntDone) stNext = S_COLSU;
      S_COLSU: begin
        stNext   = S_CASLO;
        waitNext = CAS_LOAD;
      end
      S_CASLO: if (cntDone) stNext = S_OPEN;
      S_OPEN: begin
        if (refPend || (reqValid && !rowHit)) begin
          stNext   = S_PRE;
          waitNext = RP_LOAD;
        end else if (accept) begin
          stNext = S_COLSU;
        end
      end
      S_REFC: begin
        stNext   = S_REFR;
        waitNext = REF_LOAD;
      end
      S_REFR: begin
        if (cntDone) begin
          stNext   = S_PRE;
          waitNext = RP_LOAD;
        end
      end
      default: stNext = S_PRE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= S_PRE;
      waitCnt <= RP_LOAD;
    end else begin
      st      <= stNext;
      waitCnt <= waitNext;
    end
  end

  // distributed refresh timer; a new tick wins over the clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refTimer <= '0;
      refPend  <= 1'b0;
    end else if (refTimer == REF_LAST) begin
      refTimer <= '0;
      refPend  <= 1'b1;
    end else begin
      refTimer <= refTimer + 1'b1;
      if (st == S_REFC) refPend <= 1'b0;
    end
  end

  logic colPhase, inRefresh;
  assign colPhase  = (st == S_COLSU) || (st == S_CASLO);
  assign inRefresh = (st == S_REFC) || (st == S_REFR);

  assign ctl.loadReq   = accept;
  assign ctl.selCol    = colPhase;
  assign ctl.driveData = colPhase && curWrite;
  assign ctl.capture   = (st == S_CASLO) && !curWrite && (waitCnt == CAP_AT);

  assign memRasN = !((st == S_ACT) || colPhase || (st == S_OPEN) || (st == S_REFR));
  assign memWeN  = !(colPhase && curWrite);
  assign memOeN  = !((st == S_CASLO) && !curWrite);

  for (genvar i = 0; i < LANES; i++) begin : gCas
    assign memCasN[i] = !(((st == S_CASLO) && curMask[i]) || inRefresh);
  end

endmodule

// File: rtl/page_dram_ctrl.sv
module page_dram_ctrl
  import pdc_pkg::*;
#(
  parameter int ADDR_BITS    = 10,
  parameter int DATA_W       = 16,
  parameter int T_RP         = 3,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 3,
  parameter int T_LAT        = 2,
  parameter int REF_INTERVAL = 12500
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic                   reqWrite,
  input  logic [2*ADDR_BITS-1:0] reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  input  logic [DATA_W/8-1:0]    reqMask,
  output logic                   rdValid,
  output logic [DATA_W-1:0]      rdData,
  output logic [ADDR_BITS-1:0]   memAddr,
  output logic                   memRasN,
  output logic [DATA_W/8-1:0]    memCasN,
  output logic                   memWeN,
  output logic                   memOeN,
  output logic [DATA_W-1:0]      memDout,
  output logic                   memDoutEn,
  input  logic [DATA_W-1:0]      memDin
);

  localparam int LANES = DATA_W / 8;

  pdcStrobe_t       ctl;
  logic             rowHit, curWrite;
  logic [LANES-1:0] curMask;

  pdc_control #(
    .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_LAT(T_LAT),
    .REF_INTERVAL(REF_INTERVAL), .LANES(LANES)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rowHit(rowHit),
    .curMask(curMask), .curWrite(curWrite), .reqReady(reqReady), .ctl(ctl),
    .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN), .memOeN(memOeN)
  );

  pdc_datapath #(.ADDR_BITS(ADDR_BITS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqMask(reqMask), .reqWrite(reqWrite), .memDin(memDin), .rowHit(rowHit),
    .curMask(curMask), .curWrite(curWrite), .memAddr(memAddr), .memDout(memDout),
    .memDoutEn(memDoutEn), .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: rtl/page_dram_ctrl_chk.sv
module page_dram_ctrl_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             rasN,
  input logic [LANES-1:0] casN,
  input logic             weN,
  input logic             oeN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             rdValid,
  input logic             doutEn
);

  // refresh ordering: column strobes first, row strobe the cycle after
  assert_cbr_order_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((casN != '1) && ($past(casN) == '1) && rasN) |=> !rasN);

  // write enable only falls while every column strobe is high
  assert_we_setup_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(weN) |-> (casN == '1));

  assert_oe_we_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(!oeN && !weN));

  assert_write_drive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> doutEn);

  assert_rd_after_oe_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(!oeN));

  assert_hit_keeps_row_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !rasN) |=> !rasN);

  assert_no_accept_in_cas_R8: assert property (@(posedge clk) disable iff (!rstN)
    (casN != '1) |-> !reqReady);

  assert_close_clean_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (casN == '1));

endmodule

bind page_dram_ctrl page_dram_ctrl_chk #(.LANES(DATA_W / 8)) u_chk (
  .clk(clk), .rstN(rstN), .rasN(memRasN), .casN(memCasN), .weN(memWeN),
  .oeN(memOeN), .reqValid(reqValid), .reqReady(reqReady), .rdValid(rdValid),
  .doutEn(memDoutEn)
);

// File: tb/sim_page_dram_ctrl.sv
`timescale 1ns/1ps
module sim_page_dram_ctrl;

  localparam int TRP = 3, TRCD = 2, TCAS = 3, TLAT = 2, RI = 250;
  localparam int P_PRE = 0, P_IDLE = 1, P_ACT = 2, P_COLSU = 3,
                 P_CASLO = 4, P_OPEN = 5, P_REFC = 6, P_REFR = 7;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = 2'b11;
  logic        reqReady, rdValid, memRasN, memWeN, memOeN, memDoutEn;
  logic [15:0] rdData, memDout, memDin;
  logic [9:0]  memAddr;
  logic [1:0]  memCasN;

  assign memDin = {~memAddr[7:0], memAddr[7:0]};

  page_dram_ctrl #(.T_RP(TRP), .T_RCD(TRCD), .T_CAS(TCAS), .T_LAT(TLAT),
                   .REF_INTERVAL(RI)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr), .memRasN(memRasN),
    .memCasN(memCasN), .memWeN(memWeN), .memOeN(memOeN), .memDout(memDout),
    .memDoutEn(memDoutEn), .memDin(memDin)
  );

  int checks = 0, fails = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          mPh, mAge, mRefT;
  logic        mPend, mWr, mRdV, mHit, mAcc;
  logic [9:0]  mRow, mCol;
  logic [1:0]  mMask;
  logic [15:0] mData, mRdD;

  task automatic goPh(input int p);
    mPh  <= p;
    mAge <= 0;
  endtask

  function automatic logic modelReady();
    return !mPend && (mPh == P_IDLE || (mPh == P_OPEN && reqAddr[19:10] == mRow));
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPh <= P_PRE; mAge <= 0; mRefT <= 0; mPend <= 1'b0; mRdV <= 1'b0;
      mRdD <= '0; mRow <= '0; mCol <= '0; mWr <= 1'b0; mMask <= 2'b11; mData <= '0;
    end else begin
      mHit = (reqAddr[19:10] == mRow);
      mAcc = reqValid && modelReady();
      if (mRefT == RI - 1) begin
        mRefT <= 0; mPend <= 1'b1;
      end else begin
        mRefT <= mRefT + 1;
        if (mPh == P_REFC) mPend <= 1'b0;
      end
      mRdV <= 1'b0;
      if (mPh == P_CASLO && !mWr && mAge == TLAT - 1) begin
        mRdV <= 1'b1;
        mRdD <= {mMask[1] ? ~mCol[7:0] : 8'h00, mMask[0] ? mCol[7:0] : 8'h00};
      end
      if (mAcc) begin
        mRow <= reqAddr[19:10]; mCol <= reqAddr[9:0]; mWr <= reqWrite;
        mMask <= (reqMask == 2'b00) ? 2'b11 : reqMask; mData <= reqWdata;
      end
      mAge <= mAge + 1;
      case (mPh)
        P_PRE:   if (mAge == TRP - 1) goPh(P_IDLE);
        P_IDLE:  if (mPend) goPh(P_REFC); else if (mAcc) goPh(P_ACT);
        P_ACT:   if (mAge == TRCD - 1) goPh(P_COLSU);
        P_COLSU: goPh(P_CASLO);
        P_CASLO: if (mAge == TCAS - 1) goPh(P_OPEN);
        P_OPEN:  if (mPend || (reqValid && !mHit)) goPh(P_PRE);
                 else if (mAcc) goPh(P_COLSU);
        P_REFC:  goPh(P_REFR);
        P_REFR:  if (mAge == TRCD + TCAS - 1) goPh(P_PRE);
        default: goPh(P_PRE);
      endcase
    end
  end

  // ---------------- per-cycle comparison ----------------
  bit started = 1'b0;
  always @(negedge clk) begin
    if (started) begin
      logic colPh, refPh;
      colPh = (mPh == P_COLSU) || (mPh == P_CASLO);
      refPh = (mPh == P_REFC) || (mPh == P_REFR);
      chk("R9 row strobe", memRasN,
          !(mPh == P_ACT || colPh || mPh == P_OPEN || mPh == P_REFR));
      for (int i = 0; i < 2; i++)
        chk("R4 column strobe lane", memCasN[i], !((mPh == P_CASLO && mMask[i]) || refPh));
      chk("R5 write enable", memWeN, !(colPh && mWr));
      chk("R5 output enable", memOeN, !(mPh == P_CASLO && !mWr));
      chk("R5 data drive", memDoutEn, colPh && mWr);
      if (colPh && mWr) chk("R5 write data", memDout, mData);
      if (colPh) chk("R2 column address", memAddr, mCol);
      if (mPh == P_ACT || mPh == P_OPEN) chk("R2 row address", memAddr, mRow);
      chk("R8 ready", reqReady, modelReady());
      chk("R7 read valid", rdValid, mRdV);
      if (mRdV) chk("R7 read data", rdData, mRdD);
    end
  end

  // ---------------- timing monitor on the pins ----------------
  int  cyc = 0, refCount = 0, rasLowAge = 0, rasHighRun = 0, casRun = 0;
  bit  prevRas = 1'b1, prevAny = 1'b0, firstCas = 1'b0, inCbr = 1'b0, cbrNext = 1'b0;
  always @(negedge clk) begin
    if (started) begin
      bit anyCas;
      anyCas = (memCasN != 2'b11);
      cyc++;
      if (cbrNext) begin
        chk("R11 row strobe follows refresh column strobes", memRasN, 1'b0);
        chk("R11 write enable high in refresh", memWeN, 1'b1);
        cbrNext = 1'b0;
      end
      if (memRasN) rasHighRun++; else rasHighRun = 0;
      if (prevRas && !memRasN) begin rasLowAge = 0; firstCas = !anyCas; end
      else rasLowAge++;
      if (!prevAny && anyCas) begin
        casRun = 1;
        if (memRasN) begin
          chk("R12 precharge before refresh", rasHighRun >= TRP, 1);
          refCount++; inCbr = 1'b1; cbrNext = 1'b1;
        end else begin
          inCbr = 1'b0;
          if (firstCas) chk("R3 row-to-column delay", rasLowAge, TRCD + 1);
          firstCas = 1'b0;
        end
      end else if (anyCas) casRun++;
      if (prevAny && !anyCas) begin
        if (inCbr) chk("R11 refresh strobe length", casRun, TRCD + TCAS + 1);
        else       chk("R6 column pulse width", casRun, TCAS);
      end
      prevRas = memRasN;
      prevAny = anyCas;
    end
  end

  // ---------------- stimulus ----------------
  task automatic doReq(input logic wr, input logic [9:0] row, input logic [9:0] col,
                       input logic [15:0] d, input logic [1:0] m);
    @(posedge clk); #1;
    reqValid = 1'b1; reqWrite = wr; reqAddr = {row, col}; reqWdata = d; reqMask = m;
    do @(negedge clk); while (!reqReady);
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R8 actual=hung expected=complete");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset row strobe", memRasN, 1'b1);
    chk("R1 reset column strobes", memCasN, 2'b11);
    chk("R1 reset write enable", memWeN, 1'b1);
    chk("R1 reset output enable", memOeN, 1'b1);
    chk("R1 reset ready", reqReady, 1'b0);
    chk("R1 reset read valid", rdValid, 1'b0);
    @(posedge clk); #1;
    rstN = 1'b1; started = 1'b1;
    repeat (TRP - 1) begin
      @(negedge clk);
      chk("R1 precharge after reset", reqReady, 1'b0);
    end
    // page open, word write then hits with each lane mask
    doReq(1'b1, 10'h012, 10'h034, 16'hBEEF, 2'b11);
    doReq(1'b0, 10'h012, 10'h035, 16'h0000, 2'b11);
    doReq(1'b1, 10'h012, 10'h036, 16'h1234, 2'b01);
    doReq(1'b0, 10'h012, 10'h037, 16'h0000, 2'b10);
    doReq(1'b1, 10'h012, 10'h038, 16'hA5C3, 2'b00);
    doReq(1'b0, 10'h012, 10'h039, 16'h0000, 2'b01);
    doReq(1'b0, 10'h012, 10'h03A, 16'h0000, 2'b00);
    // row miss, then a hit in the new row
    doReq(1'b0, 10'h2AB, 10'h3FF, 16'h0000, 2'b11);
    doReq(1'b1, 10'h2AB, 10'h000, 16'h7E81, 2'b10);
    // leave the page open across a refresh
    repeat (RI + 20) @(posedge clk);
    doReq(1'b0, 10'h2AB, 10'h155, 16'h0000, 2'b11);
    // mixed traffic over several refresh intervals
    for (int i = 0; i < 120; i++) begin
      doReq(i % 3 == 0, 10'(i % 4), 10'(i * 7), 16'(i * 16'h0911), 2'(i % 4));
      if (i % 9 == 0) repeat (i % 5) @(posedge clk);
    end
    repeat (RI + 30) @(posedge clk);
    @(negedge clk);
    chk("R10 refresh count", (cyc / RI - refCount) inside {0, 1}, 1);
    finishRun();
  end

endmodule